// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block builds a 20-bit byte address in a 1 MB space from a 16-bit segment base and a 16-bit offset. It keeps four 16-bit segment bases: code, data, stack and extra. The base is moved up by four bit positions and the offset is added to it. Each segment therefore begins on a 16-byte boundary and spans 64 KB. The sum is cut to 20 bits, so an address past the top of memory wraps back to the bottom.

The kind of access picks the default segment. An instruction fetch, which is addressed by the instruction pointer, always uses the code segment. A stack-relative access, made through the stack or base pointer, defaults to the stack segment. A general data access defaults to the data segment. The destination of a string operation uses the extra segment.

A caller can supply a valid override selector. This override replaces the default for stack-relative and general data accesses only. The bases are written through a synchronous load port. The address path is combinational from the stored bases, the selection inputs and the offset. Working out the offset from an addressing mode is left to the caller.

Top module: `seg_addr_gen`

## Requirements
- R1: Reset sets the code base to 0xFFFF and the data, stack and extra bases to 0x0000.
- R2: `phys_addr` equals (selected base × 16 + `offset`), with the base and the offset treated as unsigned. `phys_addr[3:0]` always equals `offset[3:0]`.
- R3: When base × 16 + offset is above 0xFFFFF, the result wraps modulo 2^20. For example, base 0xFFFF with offset 0x0010 gives 0x00000.
- R4: When `acc_kind` is 0 (instruction fetch), the code segment is used. `ovr_vld` and `ovr_sel` have no effect in this case.
- R5: When `acc_kind` is 1 (stack-relative) and `ovr_vld` is 0, the stack segment is used.
- R6: When `acc_kind` is 2 (general data) and `ovr_vld` is 0, the data segment is used.
- R7: When `acc_kind` is 3 (string destination), the extra segment is used. `ovr_vld` and `ovr_sel` have no effect in this case.
- R8: When `acc_kind` is 1 or 2 and `ovr_vld` is 1, the segment named by `ovr_sel` is used.
- R9: When `ld_en` is 1 at a rising clock edge, `ld_val` is written into the base named by `ld_sel`. The new value is visible right after that edge. In the cycle of the load, the old value is still used. No other base changes.
- R10: `seg_used` gives the index of the segment used: 0 = code, 1 = data, 2 = stack, 3 = extra. The same encoding applies to `ld_sel` and `ovr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write enable for a segment base |
| ld_sel | input | 2 | Segment index to write |
| ld_val | input | 16 | New base value |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| ovr_vld | input | 1 | Override selector is valid |
| ovr_sel | input | 2 | Override segment index |
| offset | input | 16 | Byte offset within the segment |
| phys_addr | output | 20 | Physical byte address |
| seg_used | output | 2 | Index of the segment used |

## Verification
The bench goes after the carry out of bit 19. The code base after reset, 0xFFFF, plus an offset of 0x10 must give zero. A design that keeps a 21st bit, or saturates instead of wrapping, gives the wrong address here. The bench sends an active override together with a fetch and together with a string destination. A design that lets the override through would report the wrong `seg_used` value. The bench also reads a base in the same cycle as its load and in the cycle after, and checks that the bases not written keep their values. This catches a write path that is combinational instead of registered, and a decoder that writes the wrong entry.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int NSEG   = 4;
    localparam int SHIFT  = 4;
    localparam int IDX_W  = $clog2(NSEG);
    localparam int ADDR_W = SEG_W + SHIFT;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_STACK  = 2'd1,
        ACC_DATA   = 2'd2,
        ACC_STRDST = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_idx_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int NSEG     = seg_pkg::NSEG,
    parameter int SEG_W    = seg_pkg::SEG_W,
    parameter int CODE_IDX = 0,
    parameter logic [SEG_W-1:0] CODE_RST = '1,
    localparam int IDX_W   = $clog2(NSEG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [SEG_W-1:0]               wr_val,
    output logic [NSEG-1:0][SEG_W-1:0]     seg_o
);

    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] seg;
    } state_t;

    state_t state_d, state_q;
    logic [NSEG-1:0][SEG_W-1:0] rst_img;

    // Reset image: the code entry starts at its own value, the others start at zero.
    for (genvar g = 0; g < NSEG; g++) begin : g_rst
        if (g == CODE_IDX) begin : g_code
            assign rst_img[g] = CODE_RST;
        end else begin : g_zero
            assign rst_img[g] = '0;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.seg[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.seg <= rst_img;
        end else begin
            state_q <= state_d;
        end
    end

    assign seg_o = state_q.seg;

endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_pkg::*;
(
    input  acc_kind_e kind_i,
    input  logic      ovr_vld_i,
    input  seg_idx_e  ovr_sel_i,
    output seg_idx_e  idx_o
);

    seg_idx_e dflt;

    always_comb begin
        unique case (kind_i)
            ACC_FETCH:  dflt = SEG_CODE;
            ACC_STACK:  dflt = SEG_STACK;
            ACC_DATA:   dflt = SEG_DATA;
            default:    dflt = SEG_EXTRA;
        endcase
    end

    // The override only applies to accesses through stack or data pointers.
    always_comb begin
        idx_o = dflt;
        if (ovr_vld_i && (kind_i == ACC_STACK || kind_i == ACC_DATA)) begin
            idx_o = ovr_sel_i;
        end
    end

endmodule

// File: rtl/seg_addr_sum.sv
module seg_addr_sum #(
    parameter int SEG_W = seg_pkg::SEG_W,
    parameter int OFF_W = seg_pkg::OFF_W,
    parameter int SHIFT = seg_pkg::SHIFT,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  base_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] base_sh;
    logic [ADDR_W-1:0] off_ext;

    assign base_sh = {base_i, {SHIFT{1'b0}}};
    assign off_ext = ADDR_W'(off_i);
    // The sum is cut to ADDR_W bits, so it wraps at the top of the space.
    assign addr_o  = base_sh + off_ext;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [IDX_W-1:0]     ld_sel,
    input  logic [SEG_W-1:0]     ld_val,
    input  logic [1:0]           acc_kind,
    input  logic                 ovr_vld,
    input  logic [IDX_W-1:0]     ovr_sel,
    input  logic [OFF_W-1:0]     offset,
    output logic [ADDR_W-1:0]    phys_addr,
    output logic [IDX_W-1:0]     seg_used
);

    logic [NSEG-1:0][SEG_W-1:0] seg_vals;
    seg_idx_e                   sel_idx;
    logic [SEG_W-1:0]           base;

    seg_regfile #(
        .NSEG     (NSEG),
        .SEG_W    (SEG_W),
        .CODE_IDX (int'(SEG_CODE)),
        .CODE_RST ({SEG_W{1'b1}})
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ld_en),
        .wr_idx (ld_sel),
        .wr_val (ld_val),
        .seg_o  (seg_vals)
    );

    seg_select u_sel (
        .kind_i    (acc_kind_e'(acc_kind)),
        .ovr_vld_i (ovr_vld),
        .ovr_sel_i (seg_idx_e'(ovr_sel)),
        .idx_o     (sel_idx)
    );

    assign base = seg_vals[sel_idx];

    seg_addr_sum #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_sum (
        .base_i (base),
        .off_i  (offset),
        .addr_o (phys_addr)
    );

    assign seg_used = sel_idx;

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
    import seg_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ld_en,
    input logic [IDX_W-1:0]     ld_sel,
    input logic [SEG_W-1:0]     ld_val,
    input logic [1:0]           acc_kind,
    input logic                 ovr_vld,
    input logic [IDX_W-1:0]     ovr_sel,
    input logic [OFF_W-1:0]     offset,
    input logic [ADDR_W-1:0]    phys_addr,
    input logic [IDX_W-1:0]     seg_used
);

    p_low_nibble_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[3:0] == offset[3:0]);

    p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_kind == 2'd0 |-> seg_used == 2'd0);

    p_stack_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd1 && !ovr_vld) |-> seg_used == 2'd2);

    p_data_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd2 && !ovr_vld) |-> seg_used == 2'd1);

    p_strdst_extra_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_kind == 2'd3 |-> seg_used == 2'd3);

    p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_kind == 2'd1 || acc_kind == 2'd2) && ovr_vld) |-> seg_used == ovr_sel);

    // A base loaded at the previous edge shows up when it is read at offset 0.
    p_load_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_en) && seg_used == $past(ld_sel) && offset == '0)
        |-> phys_addr[ADDR_W-1:SHIFT] == $past(ld_val));

endmodule

bind seg_addr_gen seg_addr_chk u_chk (.*);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_val = '0;
    logic [1:0]  acc_kind = '0;
    logic        ovr_vld = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] offset = '0;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_addr_gen u0 (.*);

    typedef struct packed {
        logic [1:0]  kind;
        logic        ov;
        logic [1:0]  os;
        logic [15:0] off;
        logic [19:0] addr;
        logic [1:0]  seg;
    } vec_t;

    // Bases loaded before the table: code 1234, data 2000, stack 3A00, extra F000.
    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 2'd0, 16'h0010, 20'h12350, 2'd0},
        '{2'd0, 1'b1, 2'd1, 16'h0005, 20'h12345, 2'd0},
        '{2'd1, 1'b0, 2'd0, 16'h0100, 20'h3A100, 2'd2},
        '{2'd2, 1'b0, 2'd0, 16'hABCD, 20'h2ABCD, 2'd1},
        '{2'd3, 1'b0, 2'd0, 16'h0001, 20'hF0001, 2'd3},
        '{2'd3, 1'b1, 2'd2, 16'h0002, 20'hF0002, 2'd3},
        '{2'd2, 1'b1, 2'd3, 16'h1000, 20'hF1000, 2'd3},
        '{2'd1, 1'b1, 2'd1, 16'h0020, 20'h20020, 2'd1},
        '{2'd2, 1'b1, 2'd0, 16'h0001, 20'h12341, 2'd0},
        '{2'd3, 1'b0, 2'd0, 16'hFFFF, 20'hFFFFF, 2'd3},
        '{2'd1, 1'b1, 2'd0, 16'hFFFF, 20'h2233F, 2'd0}
    };
    localparam string VTAG [NV] = '{"R4", "R4", "R5", "R6", "R7", "R7",
                                    "R8", "R8", "R8", "R2", "R2"};

    task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic look(input logic [1:0] k, input logic ov, input logic [1:0] os,
                        input logic [15:0] off);
        @(negedge clk);
        acc_kind = k; ovr_vld = ov; ovr_sel = os; offset = off;
        #1;
    endtask

    task automatic load(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, read through each default path
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        chk("R1 code base", phys_addr, 20'hFFFF0);
        chk("R10 fetch index", {18'd0, seg_used}, 20'd0);
        look(2'd2, 1'b0, 2'd0, 16'h0000);
        chk("R1 data base", phys_addr, 20'h00000);
        chk("R10 data index", {18'd0, seg_used}, 20'd1);
        look(2'd1, 1'b0, 2'd0, 16'h0000);
        chk("R1 stack base", phys_addr, 20'h00000);
        look(2'd3, 1'b0, 2'd0, 16'h0000);
        chk("R1 extra base", phys_addr, 20'h00000);

        // R3 wrap past the top of the space
        look(2'd0, 1'b0, 2'd0, 16'h0010);
        chk("R3 wrap to zero", phys_addr, 20'h00000);
        look(2'd0, 1'b0, 2'd0, 16'hFFFF);
        chk("R3 wrap high", phys_addr, 20'h0FFEF);

        // R9 load: old value in the load cycle, new value after the edge
        @(negedge clk);
        acc_kind = 2'd2; ovr_vld = 1'b0; offset = 16'h0000;
        ld_en = 1'b1; ld_sel = 2'd1; ld_val = 16'h2000;
        #1;
        chk("R9 old value in load cycle", phys_addr, 20'h00000);
        @(negedge clk);
        ld_en = 1'b0;
        #1;
        chk("R9 new value after edge", phys_addr, 20'h20000);
        look(2'd1, 1'b0, 2'd0, 16'h0000);
        chk("R9 stack untouched", phys_addr, 20'h00000);
        look(2'd0, 1'b0, 2'd0, 16'h0000);
        chk("R9 code untouched", phys_addr, 20'hFFFF0);

        load(2'd0, 16'h1234);
        load(2'd2, 16'h3A00);
        load(2'd3, 16'hF000);

        for (int i = 0; i < NV; i++) begin
            look(VEC[i].kind, VEC[i].ov, VEC[i].os, VEC[i].off);
            chk(VTAG[i], phys_addr, VEC[i].addr);
            chk({VTAG[i], " R10 index"}, {18'd0, seg_used}, {18'd0, VEC[i].seg});
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule